// File: doc/BRIEF.md
# Address Translation Buffer

The block is a small, fully associative store of recent page translations between a processor and the page tables. A request gives a 32-bit virtual address, a write flag and a strobe. In the same cycle the block compares the upper 20 bits, the virtual page number, against every valid slot. It returns a hit flag and a physical address made of the stored physical page number and the untouched 12-bit page offset. When no valid slot matches, it raises a miss. The requester then stalls and an external walker or handler supplies a refill. The same access, retried after the refill, hits.

Each slot keeps a valid bit, a reference bit and a dirty bit. Any hit sets the reference bit and a write hit also sets the dirty bit. A clear input drops every reference bit at once, so system software can sample recent use. A refill that marks the page absent produces a one-cycle fault pulse and installs nothing. A refill that displaces a valid slot reports the departing page number and its dirty bit, so the dirty status can be written back to the page table. A flush input invalidates the whole store in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is invalid: any request misses, and `hit`, `fault` and `evict_valid` are low.
- R2: When a request matches a valid slot, `hit` is high in the same cycle and `paddr` equals the slot's physical page number in bits 31:12 with `req_vaddr[11:0]` unchanged in bits 11:0.
- R3: `miss` is high exactly when `req_valid` is high and no valid slot holds the requested page number. `hit` and `miss` are never high together, and both are low without `req_valid`.
- R4: A refill with `refill_present` high installs the page with reference and dirty bits clear, and a retry of the request in the following cycle hits.
- R5: A refill with `refill_present` low raises `fault` for exactly the next cycle and installs nothing, so the page still misses.
- R6: A write hit sets the slot's dirty bit and a read hit leaves it unchanged. `hit_dirty` shows the bit as it stood before the current access.
- R7: Any hit sets the slot's reference bit. `hit_refd` shows the bit as it stood before the current access.
- R8: `ref_clear` clears every reference bit in one cycle. A slot that hits in that same cycle ends with its reference bit set.
- R9: A refill goes to the lowest-numbered invalid slot. When all slots are valid, it goes to the slot named by a rotating pointer that starts at 0 after reset and moves on by one, wrapping, after each such use.
- R10: When a refill replaces a valid slot, `evict_valid` is high for the next cycle only, with `evict_vpn` and `evict_dirty` giving that slot's old page number and dirty bit.
- R11: `flush` invalidates all slots in one cycle and takes priority over a refill in the same cycle, which is then dropped. The rotating pointer is not changed by a flush.
- R12: Without a hit, `paddr`, `hit_refd` and `hit_dirty` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | Request is a store |
| req_vaddr | input | 32 | Virtual address |
| hit | output | 1 | A valid slot matches the request |
| miss | output | 1 | Request present but no slot matches |
| paddr | output | 32 | Physical address on a hit, zero otherwise |
| hit_refd | output | 1 | Prior reference bit of the matching slot |
| hit_dirty | output | 1 | Prior dirty bit of the matching slot |
| refill_valid | input | 1 | Refill strobe from the walker |
| refill_vpn | input | 20 | Virtual page number being refilled |
| refill_ppn | input | 20 | Physical page number for the refill |
| refill_present | input | 1 | Page is resident in memory |
| fault | output | 1 | One-cycle pulse after a refill of an absent page |
| ref_clear | input | 1 | Clear all reference bits |
| flush | input | 1 | Invalidate all slots |
| evict_valid | output | 1 | One-cycle pulse after a valid slot was replaced |
| evict_vpn | output | 20 | Page number of the replaced slot |
| evict_dirty | output | 1 | Dirty bit of the replaced slot |

## Verification
The hardest state to reach from the ports is the rotating pointer. It is hidden, it only moves once the store is full, and a flush must leave it alone. The stimulus fills a four-slot build, makes three replacements so the pointer stands at slot 3, and then flushes while a refill arrives. It refills four pages into the emptied slots and checks that the fifth refill evicts the page in slot 3 and not the one in slot 0. Each replacement is identified at the ports by the evicted page number. Write hits placed before the replacements make the reported dirty flags differ from slot to slot.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_OFF_W = 12;
    localparam int VPN_W      = VA_W - PAGE_OFF_W;
    localparam int PPN_W      = 20;
    localparam int PA_W       = PPN_W + PAGE_OFF_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;

    typedef struct packed {
        logic valid;
        logic refd;
        logic dirty;
        vpn_t vpn;
        ppn_t ppn;
    } tlb_entry_t;

    function automatic vpn_t vpn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:PAGE_OFF_W];
    endfunction

    function automatic logic [PA_W-1:0] join_pa(input ppn_t ppn,
                                                 input logic [VA_W-1:0] va);
        return {ppn, va[PAGE_OFF_W-1:0]};
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  tlb_entry_t [ENTRIES-1:0] tbl,
    input  vpn_t                     vpn,
    output logic                     any_match,
    output logic [IDX_W-1:0]         match_idx
);

    logic [ENTRIES-1:0] match_vec;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign match_vec[i] = tbl[i].valid && (tbl[i].vpn == vpn);
        end
    endgenerate

    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
        end
    end

    assign any_match = |match_vec;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_ptr;
    logic             all_full;

    assign all_full = &valid_vec;

    always_comb begin
        victim_idx = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (take && all_full) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             hit,
    output logic             miss,
    output logic [PA_W-1:0]  paddr,
    output logic             hit_refd,
    output logic             hit_dirty,
    input  logic             refill_valid,
    input  logic [VPN_W-1:0] refill_vpn,
    input  logic [PPN_W-1:0] refill_ppn,
    input  logic             refill_present,
    output logic             fault,
    input  logic             ref_clear,
    input  logic             flush,
    output logic             evict_valid,
    output logic [VPN_W-1:0] evict_vpn,
    output logic             evict_dirty
);

    localparam int IDX_W = $clog2(ENTRIES);

    tlb_entry_t [ENTRIES-1:0] tbl;
    logic [ENTRIES-1:0]       valid_vec;
    logic                     any_match;
    logic [IDX_W-1:0]         match_idx;
    logic [IDX_W-1:0]         victim_idx;
    logic                     install;
    tlb_entry_t               hit_ent;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_vld
            assign valid_vec[i] = tbl[i].valid;
        end
    endgenerate

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .tbl       (tbl),
        .vpn       (vpn_of(req_vaddr)),
        .any_match (any_match),
        .match_idx (match_idx)
    );

    assign install = refill_valid && refill_present && !flush;

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .take       (install),
        .victim_idx (victim_idx)
    );

    assign hit       = req_valid && any_match;
    assign miss      = req_valid && !any_match;
    assign hit_ent   = tbl[match_idx];
    assign paddr     = hit ? join_pa(hit_ent.ppn, req_vaddr) : '0;
    assign hit_refd  = hit && hit_ent.refd;
    assign hit_dirty = hit && hit_ent.dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl         <= '0;
            fault       <= 1'b0;
            evict_valid <= 1'b0;
            evict_vpn   <= '0;
            evict_dirty <= 1'b0;
        end else begin
            fault       <= refill_valid && !refill_present;
            evict_valid <= 1'b0;

            if (ref_clear) begin
                for (int i = 0; i < ENTRIES; i++) tbl[i].refd <= 1'b0;
            end

            if (hit) begin
                tbl[match_idx].refd <= 1'b1;
                if (req_write) tbl[match_idx].dirty <= 1'b1;
            end

            if (flush) begin
                for (int i = 0; i < ENTRIES; i++) tbl[i].valid <= 1'b0;
            end else if (install) begin
                tbl[victim_idx] <= '{valid: 1'b1, refd: 1'b0, dirty: 1'b0,
                                     vpn: refill_vpn, ppn: refill_ppn};
                evict_valid     <= tbl[victim_idx].valid;
                evict_vpn       <= tbl[victim_idx].vpn;
                evict_dirty     <= tbl[victim_idx].dirty;
            end
        end
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             hit,
    input logic             miss,
    input logic [PA_W-1:0]  paddr,
    input logic             hit_refd,
    input logic             hit_dirty,
    input logic             refill_valid,
    input logic             refill_present,
    input logic             fault,
    input logic             flush,
    input logic             evict_valid
);

    assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(hit && miss));

    assert_miss_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
        miss |-> req_valid);

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> !hit);

    assert_fault_cause_R5: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(refill_valid && !refill_present));

    assert_evict_cause_R10: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> $past(refill_valid && refill_present && !flush));

    assert_dirty_sticks_R6: assert property (@(posedge clk) disable iff (rst)
        (hit && $stable(req_vaddr)
             && $past(hit && req_write && !flush && !refill_valid)) |-> hit_dirty);

    assert_ref_sticks_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && $stable(req_vaddr)
             && $past(hit && !flush && !refill_valid)) |-> hit_refd);

    assert_quiet_on_nohit_R12: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (paddr == '0 && !hit_refd && !hit_dirty));

endmodule

bind tlb_xlate tlb_xlate_chk u_chk (.*);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
    import tlb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid, req_write;
    logic [VA_W-1:0]  req_vaddr;
    logic             hit, miss, hit_refd, hit_dirty;
    logic [PA_W-1:0]  paddr;
    logic             refill_valid, refill_present;
    logic [VPN_W-1:0] refill_vpn;
    logic [PPN_W-1:0] refill_ppn;
    logic             fault, ref_clear, flush;
    logic             evict_valid, evict_dirty;
    logic [VPN_W-1:0] evict_vpn;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlate #(.ENTRIES(N)) u_tlb_xlate (.*);

    localparam vpn_t PA_ = 20'h00011, PB = 20'h12345, PC = 20'hABCDE, PD = 20'hFFFFF;
    localparam vpn_t PE = 20'h00000, PF = 20'h7FFFF, PG = 20'h80000, PX = 20'h00022;
    localparam vpn_t PH = 20'h01001, PI = 20'h01002, PJ = 20'h01003, PK = 20'h01004;
    localparam vpn_t PL = 20'h01005;

    function automatic ppn_t ppn_for(input vpn_t v);
        return v ^ 20'hF0F0F;
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_write = 0; req_vaddr = '0;
        refill_valid = 0; refill_present = 0; refill_vpn = '0; refill_ppn = '0;
        ref_clear = 0; flush = 0;
    endtask

    // eref/edirty of -1 mean not checked
    task automatic lookup(input logic rq, input logic wr, input logic clr,
                          input vpn_t v, input logic [11:0] off, input logic eh,
                          input int eref, input int edirty, input string tag);
        logic [PA_W-1:0] epa;
        @(negedge clk);
        req_valid = rq; req_write = wr; ref_clear = clr; req_vaddr = {v, off};
        #1;
        epa = eh ? {ppn_for(v), off} : '0;
        chk(hit == eh, {tag, " hit"}, hit, eh);
        chk(miss == (rq && !eh), {tag, " miss"}, miss, rq && !eh);
        chk(paddr == epa, {tag, " paddr"}, paddr, epa);
        if (!eh) chk(!hit_refd && !hit_dirty, {tag, " R12 status"}, {hit_refd, hit_dirty}, 0);
        if (eh && eref >= 0) chk(hit_refd == eref[0], {tag, " refd"}, hit_refd, eref);
        if (eh && edirty >= 0) chk(hit_dirty == edirty[0], {tag, " dirty"}, hit_dirty, edirty);
        @(negedge clk);
        idle();
    endtask

    task automatic refill(input vpn_t v, input logic pres, input logic fl,
                          input logic eev, input vpn_t evv, input logic evd,
                          input string tag);
        @(negedge clk);
        refill_valid = 1; refill_present = pres; refill_vpn = v;
        refill_ppn = ppn_for(v); flush = fl;
        @(negedge clk);
        idle();
        #1;
        chk(fault == !pres, {tag, " fault"}, fault, !pres);
        chk(evict_valid == eev, {tag, " evict_valid"}, evict_valid, eev);
        if (eev) begin
            chk(evict_vpn == evv, {tag, " evict_vpn"}, evict_vpn, evv);
            chk(evict_dirty == evd, {tag, " evict_dirty"}, evict_dirty, evd);
        end
        @(negedge clk);
        chk(!fault && !evict_valid, {tag, " pulse width"}, {fault, evict_valid}, 0);
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk(!hit && !miss && !fault && !evict_valid, "R1 reset outputs",
            {hit, miss, fault, evict_valid}, 0);
        lookup(1, 0, 0, PA_, 12'h000, 0, -1, -1, "R1 empty miss");

        refill(PA_, 1, 0, 0, '0, 0, "R4 install A");
        lookup(1, 0, 0, PA_, 12'h000, 1, 0, 0, "R4 retry hits clean");
        lookup(1, 0, 0, PA_, 12'hFFF, 1, 1, 0, "R7 ref set by hit");

        refill(PX, 0, 0, 0, '0, 0, "R5 absent page");
        lookup(1, 0, 0, PX, 12'h456, 0, -1, -1, "R5 nothing installed");

        lookup(1, 1, 0, PA_, 12'h123, 1, 1, 0, "R6 write sees prior clean");
        lookup(1, 0, 0, PA_, 12'h123, 1, 1, 1, "R6 dirty after write");
        lookup(1, 0, 0, PA_, 12'h124, 1, 1, 1, "R6 read keeps dirty");
        lookup(0, 0, 0, PA_, 12'h123, 0, -1, -1, "R3 no request no flags");

        refill(PB, 1, 0, 0, '0, 0, "R9 fill slot1");
        refill(PC, 1, 0, 0, '0, 0, "R9 fill slot2");
        refill(PD, 1, 0, 0, '0, 0, "R9 fill slot3");
        lookup(1, 0, 0, PB, 12'h010, 1, 0, 0, "R7 B first touch");
        lookup(1, 0, 1, PC, 12'h020, 1, 0, 0, "R8 hit during clear");
        lookup(1, 0, 0, PA_, 12'h030, 1, 0, 1, "R8 A ref cleared");
        lookup(1, 0, 0, PC, 12'h040, 1, 1, 0, "R8 same-cycle hit keeps ref");
        lookup(1, 0, 0, PB, 12'h050, 1, 0, 0, "R8 B ref cleared");

        for (int e = 0; e < 4; e++) begin
            for (int k = 0; k < 4; k++) begin
                vpn_t v;
                logic [11:0] off;
                v = (e == 0) ? PA_ : (e == 1) ? PB : (e == 2) ? PC : PD;
                off = (k == 0) ? 12'h000 : (k == 1) ? 12'h001 : (k == 2) ? 12'h800 : 12'hFFF;
                lookup(1, 0, 0, v, off, 1, -1, -1, "R2 sweep");
            end
        end

        lookup(1, 1, 0, PB, 12'h060, 1, -1, 0, "R6 write B");
        refill(PE, 1, 0, 1, PA_, 1, "R10 full evicts slot0 dirty");
        refill(PF, 1, 0, 1, PB, 1, "R9 pointer advances to slot1");
        refill(PG, 1, 0, 1, PC, 0, "R10 clean eviction");
        lookup(1, 0, 0, PA_, 12'h000, 0, -1, -1, "R9 A gone");
        lookup(1, 0, 0, PE, 12'h777, 1, 0, 0, "R4 E clean");

        refill(PH, 1, 1, 0, '0, 0, "R11 flush drops refill");
        lookup(1, 0, 0, PD, 12'h000, 0, -1, -1, "R11 D flushed");
        lookup(1, 0, 0, PE, 12'h000, 0, -1, -1, "R11 E flushed");
        lookup(1, 0, 0, PG, 12'h000, 0, -1, -1, "R11 G flushed");
        lookup(1, 0, 0, PH, 12'h000, 0, -1, -1, "R11 H not installed");

        refill(PH, 1, 0, 0, '0, 0, "R9 refill slot0 after flush");
        refill(PI, 1, 0, 0, '0, 0, "R9 slot1");
        refill(PJ, 1, 0, 0, '0, 0, "R9 slot2");
        refill(PK, 1, 0, 0, '0, 0, "R9 slot3");
        refill(PL, 1, 0, 1, PK, 0, "R11 pointer kept across flush");
        lookup(1, 0, 0, PL, 12'hABC, 1, 0, 0, "R2 L hits");
        lookup(1, 0, 0, PK, 12'hABC, 0, -1, -1, "R9 K evicted");
        lookup(1, 0, 0, PH, 12'h001, 1, 0, 0, "R9 H kept");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule